// File: doc/BRIEF.md
# Multi-Peer State and Doorbell Hub

A central hub for a group of `NUM_PEERS` communicating peers (at least two). Each peer hands the hub one request at a time, either a doorbell or a write of its own 32-bit state. The hub keeps a copy of every peer's state. It writes any state change into an external state table, at the entry whose index is the peer's number. It then raises a one-cycle interrupt, carrying a vector number, toward each peer that should hear about the event. When a peer is reset or disconnected, its state is forced to zero, and the hub handles this exactly like a state write.

A doorbell names a target peer and a vector. It reaches the target only when four things hold: the target exists, it is active (its state entry is nonzero), its interrupts are enabled, and the requested vector is enabled in the target's vector mask. Otherwise the doorbell is silently dropped. A state write that changes the stored value goes to the table first and then sends vector 0 to every other peer whose interrupts and vector 0 are enabled. A write that repeats the stored value does nothing. Requests that arrive together are served round-robin, one per cycle. The interrupt transport and the memory fabric are outside the block.

Top module: `peer_hub`

## Requirements
- R1: After reset all outputs are zero and every state entry reads as zero, so every peer starts inactive.
- R2: An accepted state write whose value differs from the stored value drives `tbl_we_o` high in the cycle after acceptance, with `tbl_idx_o` set to the writer and `tbl_data_o` set to the new value.
- R3: An accepted state write equal to the stored value causes no table write and no interrupt.
- R4: A state change raises `irq_valid_o` with vector 0 one cycle after its table write. It goes to every peer other than the writer whose `irq_en_i` bit and vector-0 mask bit were set in the acceptance cycle.
- R5: A one-cycle pulse on `peer_rst_i[p]` later makes the hub store zero for peer p. If the old value was nonzero, this is treated as a state change (R2, R4); otherwise nothing happens.
- R6: Doorbell data holds the vector in bits 15:0 and the target peer number in bits 31:16. A deliverable doorbell raises `irq_valid_o[target]` with that vector two cycles after acceptance.
- R7: A doorbell whose target number is `NUM_PEERS` or more, or whose target has a zero state entry, is dropped.
- R8: A doorbell is dropped if the target's `irq_en_i` bit is clear, if the vector is `NUM_VEC` or more, or if the target's mask bit for that vector is clear. State-change interrupts likewise skip peers that have `irq_en_i` clear.
- R9: At most one request is served per cycle, chosen round-robin starting after the last peer served. Peer 0 comes first after reset. `req_ready_o` marks the accepted request.
- R10: A pending reset of a peer is served through the arbiter in place of that peer's request. The request is held, not accepted (`req_ready_o` stays low), and is served later.
- R11: `irq_vec_o` of a peer is zero in every cycle in which its `irq_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_PEERS | Request present, one bit per peer |
| req_kind_i | input | NUM_PEERS | 1 = state write, 0 = doorbell |
| req_data_i | input | NUM_PEERS*32 | Per-peer request data, peer p at bits 32p+31:32p |
| req_ready_o | output | NUM_PEERS | Request of that peer accepted this cycle |
| peer_rst_i | input | NUM_PEERS | Peer reset/disconnect pulse |
| irq_en_i | input | NUM_PEERS | Peer accepts interrupts |
| vec_en_i | input | NUM_PEERS*NUM_VEC | Per-peer enabled-vector mask, peer p at bits NUM_VEC*p upward |
| irq_valid_o | output | NUM_PEERS | One-cycle interrupt toward the peer |
| irq_vec_o | output | NUM_PEERS*16 | Vector number per peer, peer p at bits 16p+15:16p |
| tbl_we_o | output | 1 | State-table write strobe |
| tbl_idx_o | output | $clog2(NUM_PEERS) | State-table entry written |
| tbl_data_o | output | 32 | Value written |

## Verification
The assertions take for granted that a requester holds its valid bit, kind and data steady until `req_ready_o` accepts them. They also assume that enables are sampled in the acceptance cycle, so an enable that changes while an event is in flight does not retract it. The bench drives requests from per-peer queues and advances each queue only on the cycle its own model grants. Enables and masks change only on falling edges between scenarios. Reset pulses last exactly one cycle and are issued both while the same peer has queued work and against a peer already at zero.

// File: rtl/peer_hub_pkg.sv
package peer_hub_pkg;
  localparam int STATE_W = 32;
  localparam int VEC_W   = 16;
  localparam int TGT_W   = 16;

  typedef enum logic {
    KIND_DOORBELL = 1'b0,
    KIND_STATE    = 1'b1
  } req_kind_e;
endpackage

// File: rtl/peer_hub_arb.sv
module peer_hub_arb #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [IW-1:0] last_q;
  logic [N-1:0]  gnt_prev_q;

  // search starts one past the last served peer
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int c;
      logic [IW-1:0] ci;
      c = int'(last_q) + k;
      if (c >= N) c = c - N;
      ci = IW'(c);
      if (!any_o && req_i[ci]) begin
        any_o     = 1'b1;
        gnt_o[ci] = 1'b1;
        idx_o     = ci;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q     <= IW'(N - 1);
      gnt_prev_q <= '0;
    end else begin
      if (any_o) last_q <= idx_o;
      gnt_prev_q <= gnt_o;
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R9

  AST_RR_REPEAT_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|gnt_o) && (gnt_o == gnt_prev_q)) |-> ($countones(req_i) == 1)); // R9
endmodule

// File: rtl/peer_hub_state.sv
module peer_hub_state
  import peer_hub_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  req_kind_e          kind_i,
  input  logic [IW-1:0]      src_i,
  input  logic [STATE_W-1:0] data_i,
  output logic               chg_o,
  output logic [N-1:0]       active_o,
  output logic               tbl_we_o,
  output logic [IW-1:0]      tbl_idx_o,
  output logic [STATE_W-1:0] tbl_data_o
);
  logic [N-1:0][STATE_W-1:0] shadow_q;

  assign chg_o = acc_i && (kind_i == KIND_STATE) && (data_i != shadow_q[src_i]);

  always_comb begin
    for (int p = 0; p < N; p++) active_o[p] = |shadow_q[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q   <= '0;
      tbl_we_o   <= 1'b0;
      tbl_idx_o  <= '0;
      tbl_data_o <= '0;
    end else begin
      tbl_we_o <= chg_o;
      if (chg_o) begin
        shadow_q[src_i] <= data_i;
        tbl_idx_o       <= src_i;
        tbl_data_o      <= data_i;
      end
    end
  end

  AST_TBL_NEEDS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_o |-> $past(acc_i)); // R2

  AST_ACTIVE_TRACKS_TBL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_o |-> (active_o[tbl_idx_o] == (tbl_data_o != '0))); // R5
endmodule

// File: rtl/peer_hub_irq.sv
module peer_hub_irq
  import peer_hub_pkg::*;
#(
  parameter int N  = 4,
  parameter int NV = 4,
  localparam int IW = $clog2(N),
  localparam int VW = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 db_acc_i,
  input  logic                 chg_i,
  input  logic [IW-1:0]        src_i,
  input  logic [TGT_W-1:0]     tgt_i,
  input  logic [VEC_W-1:0]     vec_i,
  input  logic [N-1:0]         active_i,
  input  logic [N-1:0]         irq_en_i,
  input  logic [N*NV-1:0]      vec_en_i,
  output logic [N-1:0]         irq_valid_o,
  output logic [N*VEC_W-1:0]   irq_vec_o
);
  logic [N-1:0][NV-1:0]    vmask;
  logic [N-1:0]            hit_mask;
  logic [VEC_W-1:0]        hit_vec;
  logic [N-1:0]            s1_mask_q;
  logic [VEC_W-1:0]        s1_vec_q;
  logic [N-1:0][VEC_W-1:0] vec_q;
  logic [IW-1:0]           tgt_idx;
  logic                    tgt_ok;
  logic                    vec_ok;

  assign vmask   = vec_en_i;
  assign tgt_idx = tgt_i[IW-1:0];
  assign tgt_ok  = 32'(tgt_i) < N;
  assign vec_ok  = 32'(vec_i) < NV;

  always_comb begin
    hit_mask = '0;
    hit_vec  = '0;
    if (chg_i) begin
      for (int p = 0; p < N; p++)
        hit_mask[p] = (IW'(p) != src_i) && irq_en_i[p] && vmask[p][0];
    end else if (db_acc_i && tgt_ok && vec_ok) begin
      if (active_i[tgt_idx] && irq_en_i[tgt_idx] && vmask[tgt_idx][vec_i[VW-1:0]]) begin
        hit_mask[tgt_idx] = 1'b1;
        hit_vec           = vec_i;
      end
    end
  end

  // stage 1 lines up with the table write, stage 2 drives the peers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_mask_q   <= '0;
      s1_vec_q    <= '0;
      irq_valid_o <= '0;
    end else begin
      s1_mask_q   <= hit_mask;
      s1_vec_q    <= hit_vec;
      irq_valid_o <= s1_mask_q;
    end
  end

  for (genvar p = 0; p < N; p++) begin : g_peer
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vec_q[p] <= '0;
      else         vec_q[p] <= s1_mask_q[p] ? s1_vec_q : '0;
    end

    AST_IRQ_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_valid_o[p] |-> $past(irq_en_i[p], 2)); // R8

    AST_VEC_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_valid_o[p] |-> (vec_q[p] == '0)); // R11
  end

  assign irq_vec_o = vec_q;
endmodule

// File: rtl/peer_hub.sv
module peer_hub
  import peer_hub_pkg::*;
#(
  parameter int NUM_PEERS = 4,
  parameter int NUM_VEC   = 4,
  localparam int IW = $clog2(NUM_PEERS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PEERS-1:0]           req_valid_i,
  input  logic [NUM_PEERS-1:0]           req_kind_i,
  input  logic [NUM_PEERS*STATE_W-1:0]   req_data_i,
  output logic [NUM_PEERS-1:0]           req_ready_o,
  input  logic [NUM_PEERS-1:0]           peer_rst_i,
  input  logic [NUM_PEERS-1:0]           irq_en_i,
  input  logic [NUM_PEERS*NUM_VEC-1:0]   vec_en_i,
  output logic [NUM_PEERS-1:0]           irq_valid_o,
  output logic [NUM_PEERS*VEC_W-1:0]     irq_vec_o,
  output logic                           tbl_we_o,
  output logic [IW-1:0]                  tbl_idx_o,
  output logic [STATE_W-1:0]             tbl_data_o
);
  logic [NUM_PEERS-1:0][STATE_W-1:0] req_data;
  logic [NUM_PEERS-1:0] rst_pend_q;
  logic [NUM_PEERS-1:0] want;
  logic [NUM_PEERS-1:0] gnt;
  logic [IW-1:0]        gnt_idx;
  logic                 gnt_any;
  logic                 from_rst;
  req_kind_e            sel_kind;
  logic [STATE_W-1:0]   sel_data;
  logic                 chg;
  logic                 db_acc;
  logic [NUM_PEERS-1:0] active;

  assign req_data = req_data_i;
  assign want     = req_valid_i | rst_pend_q;

  peer_hub_arb #(.N(NUM_PEERS)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (want),
    .gnt_o (gnt),
    .idx_o (gnt_idx),
    .any_o (gnt_any)
  );

  // a pending reset stands in for the peer's own request
  assign from_rst    = rst_pend_q[gnt_idx];
  assign sel_kind    = from_rst ? KIND_STATE : req_kind_e'(req_kind_i[gnt_idx]);
  assign sel_data    = from_rst ? '0 : req_data[gnt_idx];
  assign req_ready_o = gnt & ~rst_pend_q;
  assign db_acc      = gnt_any && (sel_kind == KIND_DOORBELL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pend_q <= '0;
    else         rst_pend_q <= (rst_pend_q & ~gnt) | peer_rst_i;
  end

  peer_hub_state #(.N(NUM_PEERS)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (gnt_any),
    .kind_i    (sel_kind),
    .src_i     (gnt_idx),
    .data_i    (sel_data),
    .chg_o     (chg),
    .active_o  (active),
    .tbl_we_o  (tbl_we_o),
    .tbl_idx_o (tbl_idx_o),
    .tbl_data_o(tbl_data_o)
  );

  peer_hub_irq #(.N(NUM_PEERS), .NV(NUM_VEC)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .db_acc_i   (db_acc),
    .chg_i      (chg),
    .src_i      (gnt_idx),
    .tgt_i      (sel_data[31:16]),
    .vec_i      (sel_data[15:0]),
    .active_i   (active),
    .irq_en_i   (irq_en_i),
    .vec_en_i   (vec_en_i),
    .irq_valid_o(irq_valid_o),
    .irq_vec_o  (irq_vec_o)
  );

  for (genvar p = 0; p < NUM_PEERS; p++) begin : g_chk
    AST_NO_SELF_NOTIFY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tbl_we_o && tbl_idx_o == IW'(p)) |=> !irq_valid_o[p]); // R4

    AST_RST_HOLDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_pend_q[p] && req_valid_i[p]) |-> !req_ready_o[p]); // R10
  end
endmodule

// File: tb/peer_hub_tb.sv
module peer_hub_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NV = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NP-1:0]     req_valid_i = '0;
  logic [NP-1:0]     req_kind_i = '0;
  logic [NP*32-1:0]  req_data_i = '0;
  logic [NP-1:0]     req_ready_o;
  logic [NP-1:0]     peer_rst_i = '0;
  logic [NP-1:0]     irq_en_i = '1;
  logic [NP*NV-1:0]  vec_en_i = '1;
  logic [NP-1:0]     irq_valid_o;
  logic [NP*16-1:0]  irq_vec_o;
  logic              tbl_we_o;
  logic [1:0]        tbl_idx_o;
  logic [31:0]       tbl_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  peer_hub #(.NUM_PEERS(NP), .NUM_VEC(NV)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_kind_i(req_kind_i), .req_data_i(req_data_i),
    .req_ready_o(req_ready_o), .peer_rst_i(peer_rst_i), .irq_en_i(irq_en_i),
    .vec_en_i(vec_en_i), .irq_valid_o(irq_valid_o), .irq_vec_o(irq_vec_o),
    .tbl_we_o(tbl_we_o), .tbl_idx_o(tbl_idx_o), .tbl_data_o(tbl_data_o)
  );

  int tests = 0;
  int fails = 0;
  string tag = "R1";

  // reference model
  logic [31:0] m_st [NP];
  bit          m_pend [NP];
  int          m_last = NP - 1;
  logic [32:0] rbuf [NP][64];
  int          rh [NP];
  int          rt [NP];
  logic [NP-1:0] rst_now = '0;
  bit            e_we = 0;
  int            e_idx = 0;
  logic [31:0]   e_data = '0;
  logic [NP-1:0] e_irq_now = '0, e_irq_pipe = '0;
  logic [15:0]   e_vec_now = '0, e_vec_pipe = '0;

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(int p, bit kind, logic [31:0] d);
    rbuf[p][rt[p] % 64] = {kind, d};
    rt[p]++;
  endtask

  task automatic db(int p, int tgt, int vec);
    push(p, 1'b0, {tgt[15:0], vec[15:0]});
  endtask

  task automatic tick();
    int g;
    logic [NP-1:0] rst_l;
    logic [NP-1:0] exp_rdy;
    logic [NP*16-1:0] exp_vec;
    bit n_we;
    int n_idx;
    logic [31:0] n_data;
    logic [NP-1:0] n_mask;
    logic [15:0] n_vec;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      req_valid_i[p] = (rh[p] != rt[p]);
      {req_kind_i[p], req_data_i[p*32 +: 32]} = req_valid_i[p] ? rbuf[p][rh[p] % 64] : 33'd0;
    end
    rst_l = rst_now;
    peer_rst_i = rst_now;
    rst_now = '0;
    #1;
    g = -1;
    if (rst_ni) begin
      for (int k = 1; k <= NP; k++) begin
        int c;
        c = (m_last + k) % NP;
        if (g < 0 && (m_pend[c] || rh[c] != rt[c])) g = c;
      end
    end
    exp_rdy = '0;
    if (g >= 0 && !m_pend[g]) exp_rdy[g] = 1'b1;
    // R9 acceptance order
    chk(req_ready_o == exp_rdy, "ready R9", 64'(req_ready_o), 64'(exp_rdy));
    // R2 table port
    chk(tbl_we_o == e_we && (!e_we || (int'(tbl_idx_o) == e_idx && tbl_data_o == e_data)),
        "table R2", {31'd0, tbl_we_o, 30'(tbl_idx_o), tbl_data_o[1:0]},
        {31'd0, e_we, 30'(e_idx), e_data[1:0]});
    if (e_we) chk(tbl_data_o == e_data, "table data R2", 64'(tbl_data_o), 64'(e_data));
    // R4 R6 interrupts, R11 idle vectors zero
    exp_vec = '0;
    for (int p = 0; p < NP; p++) if (e_irq_now[p]) exp_vec[p*16 +: 16] = e_vec_now;
    chk(irq_valid_o == e_irq_now, "irq valid R4 R6", 64'(irq_valid_o), 64'(e_irq_now));
    chk(irq_vec_o == exp_vec, "irq vector R11", irq_vec_o, exp_vec);
    // advance the model
    n_we = 0; n_idx = 0; n_data = '0; n_mask = '0; n_vec = '0;
    if (rst_ni) begin
      if (g >= 0) begin
        bit kind;
        logic [31:0] d;
        if (m_pend[g]) begin
          kind = 1'b1; d = '0; m_pend[g] = 0;
        end else begin
          {kind, d} = rbuf[g][rh[g] % 64];
          rh[g]++;
        end
        m_last = g;
        if (kind) begin
          if (d != m_st[g]) begin
            m_st[g] = d;
            n_we = 1; n_idx = g; n_data = d;
            for (int q = 0; q < NP; q++)
              n_mask[q] = (q != g) && irq_en_i[q] && vec_en_i[q*NV];
          end
        end else begin
          int tg, vc;
          tg = int'(d[31:16]);
          vc = int'(d[15:0]);
          if (tg < NP && vc < NV && m_st[tg] != 0 && irq_en_i[tg] && vec_en_i[tg*NV + vc]) begin
            n_mask[tg] = 1'b1;
            n_vec = d[15:0];
          end
        end
      end
      for (int p = 0; p < NP; p++) if (rst_l[p]) m_pend[p] = 1;
    end
    e_irq_now = e_irq_pipe; e_vec_now = e_vec_pipe;
    e_irq_pipe = n_mask; e_vec_pipe = n_vec;
    e_we = n_we; e_idx = n_idx; e_data = n_data;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_st[p] = '0; m_pend[p] = 0; rh[p] = 0; rt[p] = 0;
    end
    // R1: outputs quiet in and after reset
    tag = "R1";
    run(3);
    rst_ni = 1'b1;
    run(2);
    // R7: inactive and nonexistent targets; R1 table starts at zero
    tag = "R7";
    db(0, 1, 0);
    db(0, 7, 0);
    run(5);
    // R2 R4: state changes fan out
    tag = "R2";
    push(1, 1, 32'd5);
    push(2, 1, 32'd9);
    push(0, 1, 32'd3);
    run(6);
    // R3: repeated value
    tag = "R3";
    push(1, 1, 32'd5);
    run(4);
    tag = "R4";
    push(3, 1, 32'h77);
    run(4);
    // R6: delivered doorbells
    tag = "R6";
    db(0, 2, 3);
    db(3, 1, 0);
    run(6);
    // R8: disabled peer and masked vectors
    tag = "R8";
    irq_en_i[3] = 1'b0;
    vec_en_i[2*NV +: NV] = 4'b0101;
    push(1, 1, 32'd6);
    db(0, 3, 0);
    db(0, 2, 1);
    db(0, 2, 2);
    db(0, 2, 9);
    run(10);
    irq_en_i = '1;
    vec_en_i = '1;
    // R9: all peers contend
    tag = "R9";
    for (int p = 0; p < NP; p++) begin
      push(p, 1, 32'(100 + p));
      db(p, (p + 1) % NP, 1);
    end
    run(14);
    // R10: reset while the peer has queued writes
    tag = "R10";
    push(2, 1, 32'h55);
    push(2, 1, 32'h56);
    rst_now[2] = 1'b1;
    run(8);
    // R5: reset to zero, then again with nothing to change
    tag = "R5";
    rst_now[1] = 1'b1;
    run(5);
    rst_now[1] = 1'b1;
    run(5);
    tag = "R7";
    db(0, 1, 0);
    run(5);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule